// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block sits beside a processor's fetch and execute stages and decides which of seven exception causes, if any, is taken. The causes are reset, data abort, fast interrupt (FIQ), normal interrupt (IRQ), prefetch abort, undefined instruction and software interrupt. Requests are level signals held by the logic that raises them. The core marks each instruction boundary with a strobe. At that strobe every unmasked request is arbitrated by a fixed priority. A reset request is honoured in any cycle.

When a cause wins, the block registers four results that appear together for one cycle: a take pulse, the processor mode to enter, the vector address to fetch from, and the link value to save. The vector is a fixed word slot per cause inside a table. The table sits at address zero, or at a high base when the high-vector select is set. The link value is always the sampled fetch PC minus four. The exception handler applies any further correction for its cause. The block neither latches nor clears requests: a request that loses stays asserted by its source and competes again at a later boundary.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Priority among eligible causes, highest first: reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R2: The vector is the table base plus a per-cause byte offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R3: The table base is 0xFFFF0000 when hivec_i is 1 in the sampled cycle, and 0x00000000 when it is 0.
- R4: mode_o gives the entered mode as a 5-bit code: supervisor 0x13 for reset and software interrupt, abort 0x17 for both aborts, undefined 0x1B, IRQ 0x12, FIQ 0x11.
- R5: link_o equals pc_i minus 4, as sampled in the cycle where the cause won, for every cause.
- R6: A mask input at 1 blocks its interrupt. With mask_fiq_i=1 an FIQ request is ignored, and with mask_irq_i=1 an IRQ request is ignored. A lower-priority eligible cause is taken instead, or nothing if there is none.
- R7: All causes except reset are considered only in a cycle where boundary_i is 1. A reset request is taken in any cycle, whatever the boundary and mask inputs.
- R8: If the undefined instruction and software interrupt requests are both asserted, the undefined instruction is taken.
- R9: A request that loses arbitration, or is suppressed, and is still asserted at a later eligible boundary is taken then.
- R10: take_o is registered: it is high in the cycle after the sampling edge and never for two cycles in a row. No cause is taken in a cycle where take_o is already high. mode_o, vector_o and link_o are zero whenever take_o is 0.
- R11: While rst_n is 0 at a clock edge, all outputs become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| boundary_i | input | 1 | Current instruction has completed |
| req_reset_i | input | 1 | Reset exception request |
| req_dabort_i | input | 1 | Data abort request |
| req_fiq_i | input | 1 | Fast interrupt request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_pabort_i | input | 1 | Prefetch abort request |
| req_undef_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software interrupt request |
| mask_irq_i | input | 1 | 1 disables IRQ |
| mask_fiq_i | input | 1 | 1 disables FIQ |
| pc_i | input | 32 | Current fetch PC |
| hivec_i | input | 1 | Selects the high vector table base |
| take_o | output | 1 | One-cycle exception-taken pulse |
| mode_o | output | 5 | Mode to enter |
| vector_o | output | 32 | Vector address to fetch |
| link_o | output | 32 | Link value to store |

## Verification
The bench targets the neighbouring priority pairs: FIQ against IRQ, data abort against FIQ, and undefined against software interrupt. A swapped priority chain would give the wrong vector and mode in these cases. It masks each interrupt while a lower cause is pending, to catch a mask that is inverted or ignored. It asserts aborts without a boundary strobe, to catch sampling that ignores the strobe. It also raises reset off-boundary with both masks set, which exposes a reset wrongly gated by either. Back-to-back eligible boundaries check that the pulse never stretches. A request that stays high after losing must be taken two cycles later. The vector base and link arithmetic are compared in every cycle, including runs of random stimulus.

// File: rtl/exc_pkg.sv
// Package: shared cause encoding, mode codes and slot mapping for the
// exception entry controller. Cause values double as priority rank
// (0 = highest), so the arbiter relies on this ordering.
package exc_pkg;

    localparam int N_CAUSE = 7;

    typedef enum logic [2:0] {
        CS_RESET = 3'd0,
        CS_DABT  = 3'd1,
        CS_FIQ   = 3'd2,
        CS_IRQ   = 3'd3,
        CS_PABT  = 3'd4,
        CS_UNDEF = 3'd5,
        CS_SWI   = 3'd6,
        CS_NONE  = 3'd7
    } cause_e;

    localparam logic [4:0] MODE_FIQ = 5'h11;
    localparam logic [4:0] MODE_IRQ = 5'h12;
    localparam logic [4:0] MODE_SVC = 5'h13;
    localparam logic [4:0] MODE_ABT = 5'h17;
    localparam logic [4:0] MODE_UND = 5'h1B;

    // Word slot within the vector table for each cause.
    function automatic logic [2:0] slot_of(input cause_e c);
        case (c)
            CS_RESET: slot_of = 3'd0;
            CS_UNDEF: slot_of = 3'd1;
            CS_SWI:   slot_of = 3'd2;
            CS_PABT:  slot_of = 3'd3;
            CS_DABT:  slot_of = 3'd4;
            CS_IRQ:   slot_of = 3'd6;
            CS_FIQ:   slot_of = 3'd7;
            default:  slot_of = 3'd5;
        endcase
    endfunction

    // Processor mode entered for each cause.
    function automatic logic [4:0] mode_of(input cause_e c);
        case (c)
            CS_RESET, CS_SWI: mode_of = MODE_SVC;
            CS_DABT, CS_PABT: mode_of = MODE_ABT;
            CS_UNDEF:         mode_of = MODE_UND;
            CS_IRQ:           mode_of = MODE_IRQ;
            CS_FIQ:           mode_of = MODE_FIQ;
            default:          mode_of = 5'h00;
        endcase
    endfunction

endpackage

// File: rtl/exc_req_gate.sv
// Request gate: turns raw requests into an eligibility vector indexed by
// priority rank. Assumes requests are levels held by their sources.
// Reset bypasses the boundary strobe and masks; a hold input blocks all
// causes for the cycle in which a take pulse is already being shown.
module exc_req_gate
    import exc_pkg::*;
(
    input  logic               hold_i,
    input  logic               boundary_i,
    input  logic               req_reset_i,
    input  logic               req_dabort_i,
    input  logic               req_fiq_i,
    input  logic               req_irq_i,
    input  logic               req_pabort_i,
    input  logic               req_undef_i,
    input  logic               req_swi_i,
    input  logic               mask_irq_i,
    input  logic               mask_fiq_i,
    output logic [N_CAUSE-1:0] elig_o
);

    logic [N_CAUSE-1:0] raw;
    logic [N_CAUSE-1:0] gate;

    // Gather raw requests in rank order.
    always_comb begin
        raw            = '0;
        raw[CS_RESET]  = req_reset_i;
        raw[CS_DABT]   = req_dabort_i;
        raw[CS_FIQ]    = req_fiq_i;
        raw[CS_IRQ]    = req_irq_i;
        raw[CS_PABT]   = req_pabort_i;
        raw[CS_UNDEF]  = req_undef_i;
        raw[CS_SWI]    = req_swi_i;
    end

    // Per-cause enable: boundary timing plus interrupt masks.
    generate
        for (genvar g = 0; g < N_CAUSE; g++) begin : g_gate
            if (g == int'(CS_RESET)) begin : g_rst
                assign gate[g] = 1'b1;
            end else if (g == int'(CS_FIQ)) begin : g_fiq
                assign gate[g] = boundary_i & ~mask_fiq_i;
            end else if (g == int'(CS_IRQ)) begin : g_irq
                assign gate[g] = boundary_i & ~mask_irq_i;
            end else begin : g_sync
                assign gate[g] = boundary_i;
            end
        end
    endgenerate

    assign elig_o = hold_i ? '0 : (raw & gate);

endmodule

// File: rtl/exc_prio_arb.sv
// Fixed-priority arbiter: lowest set index wins. Assumes bit index equals
// priority rank as defined by the cause enumeration.
module exc_prio_arb
    import exc_pkg::*;
#(
    parameter int N = N_CAUSE
) (
    input  logic [N-1:0] elig_i,
    output logic         hit_o,
    output cause_e       win_o
);

    // Scan from lowest priority up so the highest-priority request overrides.
    always_comb begin
        hit_o = 1'b0;
        win_o = CS_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                hit_o = 1'b1;
                win_o = cause_e'(i);
            end
        end
    end

endmodule

// File: rtl/exc_vec_gen.sv
// Vector generator: maps a winning cause to mode, vector address and link
// value. Assumes slot size is a power of two and the bases are aligned to
// the table size.
module exc_vec_gen
    import exc_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              SLOT_BYTES = 4,
    parameter logic [ADDR_W-1:0] LO_BASE  = '0,
    parameter logic [ADDR_W-1:0] HI_BASE  = 32'hFFFF_0000,
    parameter int              LINK_DEC   = 4
) (
    input  cause_e            cause_i,
    input  logic              hivec_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [4:0]        mode_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic [ADDR_W-1:0] link_o
);

    localparam int SLOT_SH = $clog2(SLOT_BYTES);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offs;

    // Base select and slot offset.
    always_comb begin
        base     = hivec_i ? HI_BASE : LO_BASE;
        offs     = ADDR_W'(slot_of(cause_i)) << SLOT_SH;
        vector_o = base | offs;
        mode_o   = mode_of(cause_i);
        link_o   = pc_i - ADDR_W'(LINK_DEC);
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry controller top: gates requests, arbitrates by fixed
// priority and registers a one-cycle take pulse with mode, vector and link.
// Assumes the core holds requests until served and strobes boundary_i once
// per completed instruction. Outputs are zero outside the take pulse.
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                SLOT_BYTES = 4,
    parameter logic [ADDR_W-1:0] LO_BASE    = '0,
    parameter logic [ADDR_W-1:0] HI_BASE    = 32'hFFFF_0000,
    parameter int                LINK_DEC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              req_reset_i,
    input  logic              req_dabort_i,
    input  logic              req_fiq_i,
    input  logic              req_irq_i,
    input  logic              req_pabort_i,
    input  logic              req_undef_i,
    input  logic              req_swi_i,
    input  logic              mask_irq_i,
    input  logic              mask_fiq_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              hivec_i,
    output logic              take_o,
    output logic [4:0]        mode_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic [ADDR_W-1:0] link_o
);

    logic [N_CAUSE-1:0] elig;
    logic               hit;
    cause_e             win;
    logic [4:0]         mode_n;
    logic [ADDR_W-1:0]  vec_n;
    logic [ADDR_W-1:0]  link_n;

    exc_req_gate u_gate (
        .hold_i       (take_o),
        .boundary_i   (boundary_i),
        .req_reset_i  (req_reset_i),
        .req_dabort_i (req_dabort_i),
        .req_fiq_i    (req_fiq_i),
        .req_irq_i    (req_irq_i),
        .req_pabort_i (req_pabort_i),
        .req_undef_i  (req_undef_i),
        .req_swi_i    (req_swi_i),
        .mask_irq_i   (mask_irq_i),
        .mask_fiq_i   (mask_fiq_i),
        .elig_o       (elig)
    );

    exc_prio_arb #(.N(N_CAUSE)) u_arb (
        .elig_i (elig),
        .hit_o  (hit),
        .win_o  (win)
    );

    exc_vec_gen #(
        .ADDR_W     (ADDR_W),
        .SLOT_BYTES (SLOT_BYTES),
        .LO_BASE    (LO_BASE),
        .HI_BASE    (HI_BASE),
        .LINK_DEC   (LINK_DEC)
    ) u_vec (
        .cause_i  (win),
        .hivec_i  (hivec_i),
        .pc_i     (pc_i),
        .mode_o   (mode_n),
        .vector_o (vec_n),
        .link_o   (link_n)
    );

    // Output register: capture the winner for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o   <= 1'b0;
            mode_o   <= '0;
            vector_o <= '0;
            link_o   <= '0;
        end else if (hit) begin
            take_o   <= 1'b1;
            mode_o   <= mode_n;
            vector_o <= vec_n;
            link_o   <= link_n;
        end else begin
            take_o   <= 1'b0;
            mode_o   <= '0;
            vector_o <= '0;
            link_o   <= '0;
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Checker for the exception entry controller, bound to every instance.
// Observes ports only.
module exc_entry_chk
    import exc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        boundary_i,
    input logic        req_reset_i,
    input logic        req_dabort_i,
    input logic        req_fiq_i,
    input logic        req_irq_i,
    input logic        req_pabort_i,
    input logic        req_undef_i,
    input logic        req_swi_i,
    input logic        mask_irq_i,
    input logic        mask_fiq_i,
    input logic [31:0] pc_i,
    input logic        hivec_i,
    input logic        take_o,
    input logic [4:0]  mode_o,
    input logic [31:0] vector_o,
    input logic [31:0] link_o
);

    // R10: pulse never lasts two cycles
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R10: outputs quiet outside the pulse
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (mode_o == 5'h0 && vector_o == 32'h0 && link_o == 32'h0));

    // R5: link follows the sampled PC
    assert_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> link_o == $past(pc_i) - 32'd4);

    // R3: table base follows the sampled select
    assert_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vector_o & ~32'h1F) == ($past(hivec_i) ? 32'hFFFF_0000 : 32'h0));

    // R7: only reset may be taken off a boundary
    assert_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(boundary_i || req_reset_i));

    // R1: reset wins whenever it was requested
    assert_reset_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(req_reset_i)) |-> (mode_o == MODE_SVC && vector_o[4:0] == 5'h00));

    // R6: masked IRQ is never taken
    assert_irq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && mode_o == MODE_IRQ) |-> !$past(mask_irq_i));

    // R6: masked FIQ is never taken
    assert_fiq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && mode_o == MODE_FIQ) |-> !$past(mask_fiq_i));

endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boundary_i;
    logic        req_reset_i, req_dabort_i, req_fiq_i, req_irq_i;
    logic        req_pabort_i, req_undef_i, req_swi_i;
    logic        mask_irq_i, mask_fiq_i;
    logic [31:0] pc_i;
    logic        hivec_i;
    logic        take_o;
    logic [4:0]  mode_o;
    logic [31:0] vector_o;
    logic [31:0] link_o;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R11";
    string exp_tag = "R11";

    logic        e_take;
    logic [4:0]  e_mode;
    logic [31:0] e_vec;
    logic [31:0] e_link;

    always #5 clk = ~clk;

    exc_entry_ctrl dut (.*);

    // Behavioural choice: -1 none, else 0 reset .. 6 swi
    function automatic int choose(input logic busy);
        if (busy) return -1;
        if (req_reset_i) return 0;
        if (!boundary_i) return -1;
        if (req_dabort_i) return 1;
        if (req_fiq_i && !mask_fiq_i) return 2;
        if (req_irq_i && !mask_irq_i) return 3;
        if (req_pabort_i) return 4;
        if (req_undef_i) return 5;
        if (req_swi_i) return 6;
        return -1;
    endfunction

    function automatic logic [31:0] offset_of(input int c);
        case (c)
            0: return 32'h00;
            1: return 32'h10;
            2: return 32'h1C;
            3: return 32'h18;
            4: return 32'h0C;
            5: return 32'h04;
            default: return 32'h08;
        endcase
    endfunction

    function automatic logic [4:0] mode_for(input int c);
        case (c)
            0, 6: return 5'h13;
            1, 4: return 5'h17;
            5: return 5'h1B;
            3: return 5'h12;
            default: return 5'h11;
        endcase
    endfunction

    // Reference model updated on every edge
    always @(posedge clk) begin
        int c;
        exp_tag <= cur_tag;
        if (!rst_n) begin
            e_take <= 1'b0; e_mode <= '0; e_vec <= '0; e_link <= '0;
        end else begin
            c = choose(e_take);
            if (c < 0) begin
                e_take <= 1'b0; e_mode <= '0; e_vec <= '0; e_link <= '0;
            end else begin
                e_take <= 1'b1;
                e_mode <= mode_for(c);
                e_vec  <= (hivec_i ? 32'hFFFF_0000 : 32'h0) + offset_of(c);
                e_link <= pc_i - 32'd4;
            end
        end
    end

    task automatic compare();
        checks++;
        if (take_o !== e_take || mode_o !== e_mode || vector_o !== e_vec || link_o !== e_link) begin
            failures++;
            $display("FAIL %s take=%b mode=%h vec=%h link=%h expected take=%b mode=%h vec=%h link=%h",
                     exp_tag, take_o, mode_o, vector_o, link_o, e_take, e_mode, e_vec, e_link);
        end
    endtask

    // r bits: 0 reset, 1 dabort, 2 fiq, 3 irq, 4 pabort, 5 undef, 6 swi
    task automatic step(input logic b, input logic [6:0] r, input logic mi, input logic mf,
                        input logic [31:0] pc, input logic hv, input string t);
        boundary_i   = b;
        req_reset_i  = r[0]; req_dabort_i = r[1]; req_fiq_i   = r[2];
        req_irq_i    = r[3]; req_pabort_i = r[4]; req_undef_i = r[5];
        req_swi_i    = r[6];
        mask_irq_i   = mi; mask_fiq_i = mf;
        pc_i         = pc; hivec_i = hv;
        cur_tag      = t;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        step(1'b0, 7'h00, 1'b0, 1'b0, 32'h0, 1'b0, "R10");
    endtask

    initial begin
        rst_n = 1'b0;
        // R11: reset clears outputs even with requests present
        step(1'b1, 7'h7F, 1'b0, 1'b0, 32'h100, 1'b1, "R11");
        step(1'b1, 7'h7F, 1'b0, 1'b0, 32'h104, 1'b0, "R11");
        rst_n = 1'b1;
        idle();
        // R2 R4 R5: each cause alone, low table
        for (int k = 0; k < 7; k++) begin
            step(1'b1, 7'(1 << k), 1'b0, 1'b0, 32'h3000_0000 + 32'(k * 16), 1'b0, "R2");
            idle();
        end
        // R3: each cause alone, high table
        for (int k = 0; k < 7; k++) begin
            step(1'b1, 7'(1 << k), 1'b0, 1'b0, 32'h0000_0040 + 32'(k * 8), 1'b1, "R3");
            idle();
        end
        // R1: priority pairs
        step(1'b1, 7'h7F, 1'b0, 1'b0, 32'h200, 1'b0, "R1"); idle();
        step(1'b1, 7'h7E, 1'b0, 1'b0, 32'h204, 1'b0, "R1"); idle();
        step(1'b1, 7'h1C, 1'b0, 1'b0, 32'h208, 1'b0, "R1"); idle();
        step(1'b1, 7'h18, 1'b0, 1'b0, 32'h20C, 1'b1, "R1"); idle();
        step(1'b1, 7'h70, 1'b0, 1'b0, 32'h210, 1'b0, "R1"); idle();
        // R8: undefined beats software interrupt
        step(1'b1, 7'h60, 1'b0, 1'b0, 32'h214, 1'b0, "R8"); idle();
        // R6: masks
        step(1'b1, 7'h0C, 1'b0, 1'b1, 32'h300, 1'b0, "R6"); idle();
        step(1'b1, 7'h08, 1'b1, 1'b0, 32'h304, 1'b0, "R6"); idle();
        step(1'b1, 7'h1C, 1'b1, 1'b1, 32'h308, 1'b0, "R6"); idle();
        step(1'b1, 7'h04, 1'b1, 1'b0, 32'h30C, 1'b0, "R6"); idle();
        // R7: no boundary, then reset off-boundary with masks set
        step(1'b0, 7'h7E, 1'b0, 1'b0, 32'h400, 1'b0, "R7");
        step(1'b0, 7'h01, 1'b1, 1'b1, 32'h404, 1'b1, "R7"); idle();
        // R9 R10: back-to-back boundaries, loser retried
        step(1'b1, 7'h18, 1'b0, 1'b0, 32'h500, 1'b0, "R10");
        step(1'b1, 7'h18, 1'b0, 1'b0, 32'h504, 1'b0, "R10");
        step(1'b1, 7'h10, 1'b0, 1'b0, 32'h508, 1'b0, "R9");
        idle();
        step(1'b1, 7'h01, 1'b0, 1'b0, 32'h600, 1'b0, "R10");
        step(1'b1, 7'h01, 1'b0, 1'b0, 32'h604, 1'b0, "R10");
        step(1'b1, 7'h01, 1'b0, 1'b0, 32'h608, 1'b0, "R10");
        idle();
        // R1: random mix
        for (int k = 0; k < 400; k++) begin
            step(1'($urandom), 7'($urandom) & 7'($urandom), 1'($urandom), 1'($urandom),
                 $urandom, 1'($urandom), "R1");
        end
        // R11: reset mid-run
        rst_n = 1'b0;
        step(1'b1, 7'h7F, 1'b0, 1'b0, 32'h700, 1'b0, "R11");
        rst_n = 1'b1;
        idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule